// File: doc/BRIEF.md
# Strapped Serial Register-Write Port

This block is the slave end of a serial control port. A host shifts in 24-bit words over three lines: an active-low framing line, a serial clock and a data line. Each complete word becomes a register write, presented to the register file as a one-cycle strobe in the system clock domain with a 7-bit address and 16 bits of data. The serial lines are oversampled by the system clock through a synchronizer, so they may be fully asynchronous to it.

The port protocol is chosen by a strap pin that can be low, high or undriven. An undriven pin is pulled up, so it behaves as high. High selects the three-line protocol and low asks for the two-wire protocol. The two-wire protocol itself is not built here. In that mode the block only reports the choice on its mode output and makes no writes. A designated register bit, once written as one, frees the strap pin for general use and locks the port into three-line mode until the next reset.

Top module: `sctl_port`

## Requirements
- R1: A word is shifted in MSB first, one bit on each rising edge of `ser_clk` while `latch_en` is low. Of the 24 bits, bit 23 (the first bit sent) is dropped, bits 22:16 form the address and bits 15:0 form the data.
- R2: On the rising edge of `latch_en`, a word of exactly 24 bits in three-line mode gives `wr_stb` high for exactly one system clock cycle, with `wr_addr` and `wr_data` valid in that cycle.
- R3: A frame of fewer or more than 24 bits is discarded: no `wr_stb` is produced.
- R4: `mode_3w` is 1 when the strap pin is undriven (`strap_driven`=0) or driven high. It is 0 (two-wire request) when the pin is driven low and the override is clear.
- R5: While `mode_3w` is 0, serial frames produce no `wr_stb`.
- R6: A committed write to address 9 with data bit 0 set raises `strap_free`. From then on `mode_3w` stays 1 whatever the strap pin does.
- R7: Once `strap_free` is set, later writes, including a write of 0 to bit 0 of address 9, do not clear it.
- R8: Reset clears `strap_free`, so after reset a low strap pin again gives `mode_3w`=0.
- R9: After reset, `wr_stb`=0, `wr_addr`=0, `wr_data`=0 and `strap_free`=0.
- R10: `wr_addr` and `wr_data` keep their values between strobes, including across discarded frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_en | input | 1 | Frame line; low while bits are shifted, rising edge commits |
| ser_clk | input | 1 | Serial bit clock, data sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| strap_lvl | input | 1 | Level seen on the strap pin when driven |
| strap_driven | input | 1 | 1 when something drives the strap pin, 0 when floating |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address of the write |
| wr_data | output | 16 | Register data of the write |
| mode_3w | output | 1 | 1 = three-line mode, 0 = two-wire requested |
| strap_free | output | 1 | Override latched; strap pin free for general use |

## Verification
The hardest state to reach is a locked override under a low strap pin. The bench can only set the override through a full, correctly counted write made while the pin reads high. It then has to pull the pin low and show that writes still land. The stimulus gets there in steps. It first writes address 9 with bit 0 clear, to show that this alone does nothing. It then writes it with bit 0 set, drives the strap low, and sends more frames, one of which clears the same bit. Each frame's strobe is matched against a scoreboard queue. A final reset under the low strap shows that the lock is gone.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

   typedef enum logic {
      IFM_TWO_WIRE   = 1'b0,
      IFM_THREE_LINE = 1'b1
   } ifmode_e;

   // A floating pin is pulled up, so only an actively driven low asks for two-wire.
   function automatic ifmode_e strap_decode(input logic driven, input logic lvl);
      return (driven && !lvl) ? IFM_TWO_WIRE : IFM_THREE_LINE;
   endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("sctl_sync needs at least two stages");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
   parameter int WORD_BITS = 24,
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              le,
   input  logic              sck,
   input  logic              sdi,
   input  logic              en,
   output logic              stb,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);

   localparam int PAYLOAD_W = ADDR_W + DATA_W;
   localparam int CNT_MAX   = WORD_BITS + 1;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_MAX);

   if (PAYLOAD_W > WORD_BITS) begin : g_bad_fields
      $error("address and data do not fit in the word");
   end

   logic                 le_q, sck_q;
   logic [CNT_W-1:0]     cnt;
   logic [PAYLOAD_W-1:0] shreg;
   logic                 le_rise, sck_rise, commit;

   assign le_rise  = le && !le_q;
   assign sck_rise = sck && !sck_q && !le;
   assign commit   = le_rise && (cnt == CNT_FULL) && en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         le_q  <= 1'b1;
         sck_q <= 1'b0;
         cnt   <= '0;
         shreg <= '0;
      end else begin
         le_q  <= le;
         sck_q <= sck;
         if (le) begin
            cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[PAYLOAD_W-2:0], sdi};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb  <= 1'b0;
         addr <= '0;
         data <= '0;
      end else begin
         stb <= commit;
         if (commit) begin
            addr <= shreg[PAYLOAD_W-1:DATA_W];
            data <= shreg[DATA_W-1:0];
         end
      end
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_SAT);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |-> ($stable(addr) && $stable(data)));

endmodule

// File: rtl/sctl_mode.sv
module sctl_mode #(
   parameter int ADDR_W   = 7,
   parameter int DATA_W   = 16,
   parameter int OVR_ADDR = 9,
   parameter int OVR_BIT  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_drv,
   input  logic              strap_lvl,
   input  logic              stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              mode_3w,
   output logic              ovr
);
   import sctl_pkg::*;

   if (OVR_BIT >= DATA_W) begin : g_bad_bit
      $error("override bit outside data field");
   end
   if (OVR_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("override address outside address field");
   end

   localparam logic [ADDR_W-1:0] OVR_A = ADDR_W'(OVR_ADDR);

   ifmode_e strap_mode;
   assign strap_mode = strap_decode(strap_drv, strap_lvl);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        ovr <= 1'b0;
      else if (stb && (addr == OVR_A) && data[OVR_BIT])  ovr <= 1'b1;
   end

   assign mode_3w = ovr || (strap_mode == IFM_THREE_LINE);

   p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);

   p_ovr_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |-> mode_3w);

endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
   parameter int WORD_BITS   = 24,
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int OVR_ADDR    = 9,
   parameter int OVR_BIT     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_en,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              strap_lvl,
   input  logic              strap_driven,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              mode_3w,
   output logic              strap_free
);

   localparam int          NPIN     = 5;
   // order: {strap_driven, strap_lvl, ser_dat, ser_clk, latch_en}
   localparam logic [NPIN-1:0] PIN_IDLE = 5'b01001;

   logic [NPIN-1:0] pins_raw, pins_s;

   assign pins_raw = {strap_driven, strap_lvl, ser_dat, ser_clk, latch_en};

   if (SYNC_STAGES > 0) begin : g_sync
      sctl_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) sync_i (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (pins_raw),
         .q     (pins_s)
      );
   end else begin : g_bypass
      assign pins_s = pins_raw;
   end

   sctl_shift #(.WORD_BITS(WORD_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) shift_i (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (pins_s[0]),
      .sck   (pins_s[1]),
      .sdi   (pins_s[2]),
      .en    (mode_3w),
      .stb   (wr_stb),
      .addr  (wr_addr),
      .data  (wr_data)
   );

   sctl_mode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OVR_ADDR(OVR_ADDR), .OVR_BIT(OVR_BIT)) mode_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_drv (pins_s[4]),
      .strap_lvl (pins_s[3]),
      .stb       (wr_stb),
      .addr      (wr_addr),
      .data      (wr_data),
      .mode_3w   (mode_3w),
      .ovr       (strap_free)
   );

   p_stb_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   p_commit_3w_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(mode_3w));

endmodule

// File: tb/sctl_port_tb_top.sv
`timescale 1ns/1ps
module sctl_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        latch_en = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
   logic        strap_lvl = 1'b1, strap_driven = 1'b0;
   logic        wr_stb, mode_3w, strap_free;
   logic [6:0]  wr_addr;
   logic [15:0] wr_data;

   always #2.5 clk = ~clk;

   sctl_port dut_i (
      .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .strap_lvl(strap_lvl), .strap_driven(strap_driven),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode_3w(mode_3w), .strap_free(strap_free)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic [22:0] exp_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each strobe (R1, R2)
   always @(negedge clk) begin
      if (rst_n && wr_stb) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected strobe", {wr_addr, wr_data}, 0);
         end else begin
            logic [22:0] e;
            e = exp_q.pop_front();
            check({wr_addr, wr_data} == e, "R1", "write addr/data",
                  {wr_addr, wr_data}, e);
         end
      end
   end

   task automatic send(input int nbits, input logic [31:0] w, input bit expect_wr);
      latch_en = 1'b0;
      repeat (4) @(posedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         ser_dat = w[i];
         repeat (4) @(posedge clk);
         ser_clk = 1'b1;
         repeat (4) @(posedge clk);
         ser_clk = 1'b0;
      end
      repeat (4) @(posedge clk);
      if (expect_wr) exp_q.push_back(w[22:0]);
      latch_en = 1'b1;
      repeat (12) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R2", "pending expected writes", exp_q.size(), 0);
   endtask

   task automatic chk_mode(input string req, input bit e3, input bit efree);
      repeat (6) @(posedge clk);
      @(negedge clk);
      check(mode_3w == e3, req, "mode_3w", mode_3w, e3);
      check(strap_free == efree, req, "strap_free", strap_free, efree);
   endtask

   initial begin
      #(200000 * 5);
      check(1'b0, "WD", "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R9 reset state
      check(wr_stb == 1'b0, "R9", "wr_stb", wr_stb, 0);
      check(wr_addr == 7'd0, "R9", "wr_addr", wr_addr, 0);
      check(wr_data == 16'd0, "R9", "wr_data", wr_data, 0);
      check(strap_free == 1'b0, "R9", "strap_free", strap_free, 0);
      rst_n = 1'b1;

      // R4 undriven strap -> three-line
      chk_mode("R4", 1'b1, 1'b0);
      // R1 bit 23 set but dropped
      send(24, 32'h0083_A5C3, 1'b1);

      // R4 driven high
      strap_driven = 1'b1; strap_lvl = 1'b1;
      chk_mode("R4", 1'b1, 1'b0);
      send(24, 32'h007F_0001, 1'b1);

      // R3 short and long frames discarded, R10 outputs hold
      send(23, 32'h0012_3456, 1'b0);
      send(25, 32'h0155_AAAA, 1'b0);
      @(negedge clk);
      check(wr_addr == 7'h7F, "R10", "wr_addr held", wr_addr, 7'h7F);
      check(wr_data == 16'h0001, "R10", "wr_data held", wr_data, 16'h0001);

      // R4/R5 driven low -> two-wire, no writes
      strap_lvl = 1'b0;
      chk_mode("R4", 1'b0, 1'b0);
      send(24, 32'h0011_2222, 1'b0);
      check(wr_data == 16'h0001, "R5", "wr_data held", wr_data, 16'h0001);

      // R6: bit clear does not set override, bit set does
      strap_lvl = 1'b1;
      chk_mode("R4", 1'b1, 1'b0);
      send(24, 32'h0009_FFFE, 1'b1);
      chk_mode("R6", 1'b1, 1'b0);
      send(24, 32'h0009_0001, 1'b1);
      chk_mode("R6", 1'b1, 1'b1);
      strap_lvl = 1'b0;
      chk_mode("R6", 1'b1, 1'b1);
      send(24, 32'h0042_BEEF, 1'b1);

      // R7 clearing write leaves override set
      send(24, 32'h0009_0000, 1'b1);
      chk_mode("R7", 1'b1, 1'b1);

      // R8 reset releases the lock
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      chk_mode("R8", 1'b0, 1'b0);
      send(24, 32'h0009_0001, 1'b0);
      chk_mode("R8", 1'b0, 1'b0);

      check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule